// File: doc/BRIEF.md
# Pipelined Wide Dot-Product Unit

This block forms the inner product of two vectors of signed 16-bit integers. Both vectors arrive whole on wide parallel ports together with an input strobe. Every element pair is multiplied in the same cycle, and the products are then added in a binary tree. The tree is split into register stages, and each stage holds a configurable number of addition levels, so the pipeline stays short even for long vectors. A new vector pair may be presented on every clock cycle. Each result leaves on a signed scalar port together with its own strobe, and results come out in the order the pairs went in.

The tree is sized for ELEMS elements. When ELEMS is not a power of two, the tree is padded up to the next power of two, and the extra leaves carry zero. The accumulator is wide enough that no combination of inputs can overflow.

Top module: `dotp_unit`

## Requirements
- R1: While reset is asserted, and for the first 1+STAGES cycles after it is released, dot_vld_o is low. Asserting reset clears dot_vld_o at once, even if the pipeline holds results in flight.
- R2: dot_o equals the sum over all i of v_i*u_i. Element i of each vector is the two's-complement value in bits [16*i+15 : 16*i] of vec_v_i and vec_u_i.
- R3: Let LEVELS = ceil(log2(ELEMS)) and STAGES = ceil(LEVELS / LVLS_PER_STG). The result is presented 1+STAGES rising edges after the pair is captured, counting the capturing edge as the first. With the defaults (32 elements, 4 levels per stage) this is 3 edges, and it is also 3 for 5 elements with 2 levels per stage.
- R4: A pair may be accepted on every cycle. A back-to-back stream yields one result per cycle, in input order.
- R5: dot_o is 32+LEVELS bits wide (37 bits by default) and cannot overflow. All elements at -32768 give exactly ELEMS*2^30, and the magnitude of dot_o never exceeds ELEMS*2^30.
- R6: A cycle with in_vld_i low produces a cycle with dot_vld_o low, 1+STAGES edges later. The data on the ports during such a cycle does not affect any result.
- R7: When ELEMS is not a power of two, the padding leaves contribute zero. For ELEMS=5, the result is exactly the sum of the five element products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the strobe pipeline |
| in_vld_i | input | 1 | The vector pair on the data ports is to be processed |
| vec_v_i | input | ELEMS*16 | First vector, element i in bits [16i+15:16i] |
| vec_u_i | input | ELEMS*16 | Second vector, same layout |
| dot_vld_o | output | 1 | dot_o carries a result this cycle |
| dot_o | output | 32+ceil(log2(ELEMS)) | Signed inner product |

## Verification
The hardest cases to reach are the carries through the upper accumulator bits, and a reset that lands while several results are still in flight. The bench drives vectors at the extreme values of -32768 and +32767 in every lane, to push the sum to its largest positive and negative magnitudes. It also asserts reset in the middle of a back-to-back burst and checks that the strobe drops and that no stale result appears afterwards. A second instance, with five elements and two levels per stage, covers the zero-padded tree and a different split of levels into stages at the same latency.

// File: rtl/dotp_pkg.sv
package dotp_pkg;

  // number of binary addition levels for n leaves
  function automatic int tree_levels(input int n);
    return (n <= 1) ? 0 : $clog2(n);
  endfunction

  // number of register stages in the tree
  function automatic int tree_stages(input int n, input int per_stg);
    return (tree_levels(n) + per_stg - 1) / per_stg;
  endfunction

  // addition levels resolved inside stage s
  function automatic int stage_levels(input int n, input int per_stg, input int s);
    int left;
    left = tree_levels(n) - s * per_stg;
    return (left < per_stg) ? left : per_stg;
  endfunction

endpackage

// File: rtl/dotp_mul_stage.sv
module dotp_mul_stage #(
  parameter int ELEMS  = 32,
  parameter int ELEM_W = 16,
  parameter int ACC_W  = 37,
  parameter int LEAVES = 32
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic [ELEMS*ELEM_W-1:0] vec_v,
  input  logic [ELEMS*ELEM_W-1:0] vec_u,
  output logic [LEAVES*ACC_W-1:0] leaf_q
);

  localparam int PROD_W = 2 * ELEM_W;

  logic [LEAVES*ACC_W-1:0] leaf_d;

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < ELEMS) begin : g_used
      logic signed [PROD_W-1:0] prod;
      assign prod = $signed(vec_v[i*ELEM_W +: ELEM_W]) * $signed(vec_u[i*ELEM_W +: ELEM_W]);
      assign leaf_d[i*ACC_W +: ACC_W] = ACC_W'(prod);
    end else begin : g_pad
      assign leaf_d[i*ACC_W +: ACC_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (en) leaf_q <= leaf_d;
  end

endmodule

// File: rtl/dotp_add_stage.sv
module dotp_add_stage #(
  parameter int IN_CNT = 32,
  parameter int LVLS   = 4,
  parameter int ACC_W  = 37
) (
  input  logic                                clk,
  input  logic                                en,
  input  logic [IN_CNT*ACC_W-1:0]             src,
  output logic [(IN_CNT >> LVLS)*ACC_W-1:0]   sum_q
);

  localparam int OUT_CNT = IN_CNT >> LVLS;

  logic signed [ACC_W-1:0]      acc [IN_CNT];
  logic [OUT_CNT*ACC_W-1:0]     sum_d;

  always_comb begin
    for (int i = 0; i < IN_CNT; i++) acc[i] = $signed(src[i*ACC_W +: ACC_W]);
    for (int lv = 0; lv < LVLS; lv++) begin
      for (int i = 0; i < IN_CNT / 2; i++) begin
        if (i < (IN_CNT >> (lv + 1))) acc[i] = acc[2*i] + acc[2*i+1];
      end
    end
    for (int o = 0; o < OUT_CNT; o++) sum_d[o*ACC_W +: ACC_W] = acc[o];
  end

  always_ff @(posedge clk) begin
    if (en) sum_q <= sum_d;
  end

endmodule

// File: rtl/dotp_valid_pipe.sv
module dotp_valid_pipe #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  output logic [DEPTH-1:0] stg_q
);

  logic [DEPTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = vld_i;
    for (int k = 1; k < DEPTH; k++) stg_d[k] = stg_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

endmodule

// File: rtl/dotp_unit.sv
module dotp_unit
  import dotp_pkg::*;
#(
  parameter int ELEMS        = 32,
  parameter int ELEM_W       = 16,
  parameter int LVLS_PER_STG = 4,
  localparam int LEVELS      = tree_levels(ELEMS),
  localparam int ACC_W       = 2 * ELEM_W + LEVELS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld_i,
  input  logic [ELEMS*ELEM_W-1:0] vec_v_i,
  input  logic [ELEMS*ELEM_W-1:0] vec_u_i,
  output logic                    dot_vld_o,
  output logic [ACC_W-1:0]        dot_o
);

  localparam int STAGES = tree_stages(ELEMS, LVLS_PER_STG);
  localparam int LEAVES = 1 << LEVELS;
  localparam int LAT    = 1 + STAGES;

  logic [LAT-1:0]          vld_stg;
  logic [LEAVES*ACC_W-1:0] leaf;

  dotp_valid_pipe #(.DEPTH(LAT)) u_vld (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (in_vld_i),
    .stg_q (vld_stg)
  );

  dotp_mul_stage #(
    .ELEMS(ELEMS), .ELEM_W(ELEM_W), .ACC_W(ACC_W), .LEAVES(LEAVES)
  ) u_mul (
    .clk    (clk),
    .en     (in_vld_i),
    .vec_v  (vec_v_i),
    .vec_u  (vec_u_i),
    .leaf_q (leaf)
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    localparam int DONE   = s * LVLS_PER_STG;
    localparam int LV     = stage_levels(ELEMS, LVLS_PER_STG, s);
    localparam int IN_CNT = LEAVES >> DONE;
    localparam int OUT_CNT = IN_CNT >> LV;

    logic [IN_CNT*ACC_W-1:0]  src;
    logic [OUT_CNT*ACC_W-1:0] sum;

    if (s == 0) begin : g_first
      assign src = leaf;
    end else begin : g_next
      assign src = g_stg[s-1].sum;
    end

    dotp_add_stage #(.IN_CNT(IN_CNT), .LVLS(LV), .ACC_W(ACC_W)) u_add (
      .clk   (clk),
      .en    (vld_stg[s]),
      .src   (src),
      .sum_q (sum)
    );
  end

  if (STAGES == 0) begin : g_flat
    assign dot_o = leaf;
  end else begin : g_tree
    assign dot_o = g_stg[STAGES-1].sum;
  end

  assign dot_vld_o = vld_stg[LAT-1];

endmodule

// File: rtl/dotp_unit_chk.sv
module dotp_unit_chk #(
  parameter int ELEMS  = 32,
  parameter int ELEM_W = 16,
  parameter int LAT    = 3,
  parameter int ACC_W  = 37
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld_i,
  input logic             dot_vld_o,
  input logic [ACC_W-1:0] dot_o
);

  localparam logic [ACC_W:0] BOUND = (ACC_W+1)'(ELEMS) << (2 * ELEM_W - 2);

  logic [LAT-1:0] hist;
  logic [7:0]     since_rst;
  logic [ACC_W:0] mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist      <= '0;
      since_rst <= '0;
    end else begin
      hist      <= {hist[LAT-2:0], in_vld_i};
      if (since_rst != 8'hff) since_rst <= since_rst + 8'd1;
    end
  end

  assign mag = dot_o[ACC_W-1] ? (ACC_W+1)'(-$signed(dot_o)) : {1'b0, dot_o};

  // R3 / R6: strobe follows the input strobe by exactly LAT edges
  p_strobe_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dot_vld_o == hist[LAT-1]);

  // R1: quiet after reset release
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < 8'(LAT)) |-> !dot_vld_o);

  // R2: a presented result is fully known
  p_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dot_vld_o |-> !$isunknown(dot_o));

  // R5: magnitude inside the representable product bound
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dot_vld_o |-> (mag <= BOUND));

endmodule

bind dotp_unit dotp_unit_chk #(
  .ELEMS(ELEMS), .ELEM_W(ELEM_W), .LAT(LAT), .ACC_W(ACC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_vld_i  (in_vld_i),
  .dot_vld_o (dot_vld_o),
  .dot_o     (dot_o)
);

// File: tb/tb_dotp_unit.sv
module tb_dotp_unit;

  localparam int NM  = 32;
  localparam int NO  = 5;
  localparam int LAT = 3;   // from R3 for both configurations
  localparam int RD  = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [NM*16-1:0] vv = '0;
  logic [NM*16-1:0] uu = '0;

  logic        m_vld, o_vld;
  logic [36:0] m_dot;
  logic [34:0] o_dot;

  always #5 clk = ~clk;

  dotp_unit #(.ELEMS(NM), .ELEM_W(16), .LVLS_PER_STG(4)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld_i(vld), .vec_v_i(vv), .vec_u_i(uu),
    .dot_vld_o(m_vld), .dot_o(m_dot)
  );

  dotp_unit #(.ELEMS(NO), .ELEM_W(16), .LVLS_PER_STG(2)) dut_odd (
    .clk(clk), .rst_n(rst_n), .in_vld_i(vld), .vec_v_i(vv[NO*16-1:0]),
    .vec_u_i(uu[NO*16-1:0]), .dot_vld_o(o_vld), .dot_o(o_dot)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  bit     rec_vld [RD];
  longint rec_m   [RD];
  longint rec_o   [RD];
  string  rec_tag [RD];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint dot_ref(input logic [NM*16-1:0] a, input logic [NM*16-1:0] b,
                                     input int n);
    longint s = 0;
    for (int i = 0; i < n; i++)
      s += longint'($signed(a[i*16 +: 16])) * longint'($signed(b[i*16 +: 16]));
    return s;
  endfunction

  task automatic chk(input bit ok, input string tg, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tg, act, exp, $time);
    end
  endtask

  task automatic clear_rec();
    for (int k = 0; k < RD; k++) begin
      rec_vld[k] = 1'b0; rec_m[k] = 0; rec_o[k] = 0; rec_tag[k] = "R6";
    end
  endtask

  // compare both instances against the record captured LAT edges earlier
  always @(negedge clk) begin
    if (mon_en && cyc >= LAT) begin
      int idx;
      idx = (cyc - LAT) % RD;
      chk(m_vld == rec_vld[idx], {rec_tag[idx], " strobe"}, longint'(m_vld), longint'(rec_vld[idx]));
      chk(o_vld == rec_vld[idx], "R7 strobe", longint'(o_vld), longint'(rec_vld[idx]));
      if (rec_vld[idx]) begin
        chk(longint'($signed(m_dot)) == rec_m[idx], rec_tag[idx], longint'($signed(m_dot)), rec_m[idx]);
        chk(longint'($signed(o_dot)) == rec_o[idx], "R7 padded sum", longint'($signed(o_dot)), rec_o[idx]);
      end
    end
  end

  task automatic drv(input bit valid, input logic [NM*16-1:0] a, input logic [NM*16-1:0] b,
                     input string tg);
    int idx;
    @(posedge clk); #2;
    vld = valid; vv = a; uu = b;
    idx = cyc % RD;
    rec_vld[idx] = valid;
    rec_m[idx]   = dot_ref(a, b, NM);
    rec_o[idx]   = dot_ref(a, b, NO);
    rec_tag[idx] = tg;
  endtask

  function automatic logic [NM*16-1:0] fill(input logic [15:0] e);
    logic [NM*16-1:0] r;
    for (int i = 0; i < NM; i++) r[i*16 +: 16] = e;
    return r;
  endfunction

  function automatic logic [NM*16-1:0] rnd_vec();
    logic [NM*16-1:0] r;
    for (int i = 0; i < NM; i++) r[i*16 +: 16] = 16'($urandom);
    return r;
  endfunction

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drv(1'b0, rnd_vec(), rnd_vec(), "R6");
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(m_vld == 1'b0, "R1 in reset", longint'(m_vld), 0);
    chk(o_vld == 1'b0, "R1 in reset", longint'(o_vld), 0);
    @(posedge clk); #2; rst_n = 1'b1; mon_en = 1'b1;
    idle(LAT + 1);
  endtask

  task automatic t_midstream_reset();
    for (int k = 0; k < LAT; k++) drv(1'b1, rnd_vec(), rnd_vec(), "R1");
    @(negedge clk);
    mon_en = 1'b0; vld = 1'b0; rst_n = 1'b0;
    #1;
    chk(m_vld == 1'b0, "R1 async clear", longint'(m_vld), 0);
    chk(o_vld == 1'b0, "R1 async clear", longint'(o_vld), 0);
    clear_rec();
    @(posedge clk); #2; rst_n = 1'b1; mon_en = 1'b1;
    idle(LAT + 1);
  endtask

  task automatic t_patterns();
    logic [NM*16-1:0] a, b;
    drv(1'b1, '0, '0, "R2 zeros");
    a = '0; b = '0; a[15:0] = 16'd7; b[15:0] = -16'sd9;
    drv(1'b1, a, b, "R2 lane0");
    a = '0; b = '0; a[NM*16-1 -: 16] = 16'd300; b[NM*16-1 -: 16] = 16'd1000;
    drv(1'b1, a, b, "R2 top lane");
    for (int i = 0; i < NM; i++) begin
      a[i*16 +: 16] = (i % 2) ? -16'sd123 : 16'sd456;
      b[i*16 +: 16] = 16'(i * 17 - 200);
    end
    drv(1'b1, a, b, "R2 alternating");
    idle(2);
    for (int k = 0; k < 6; k++) begin
      drv(1'b1, rnd_vec(), rnd_vec(), "R2 random");
      idle(k % 3);
    end
  endtask

  task automatic t_latency();
    idle(LAT);
    drv(1'b1, fill(16'd3), fill(16'd5), "R3 single pulse");
    idle(LAT + 1);
  endtask

  task automatic t_stream();
    for (int k = 0; k < 40; k++) drv(1'b1, rnd_vec(), rnd_vec(), "R4 back-to-back");
  endtask

  task automatic t_extremes();
    drv(1'b1, fill(16'h8000), fill(16'h8000), "R5 max positive");
    drv(1'b1, fill(16'h8000), fill(16'h7fff), "R5 max negative");
    drv(1'b1, fill(16'h7fff), fill(16'h7fff), "R5 max pos/pos");
    drv(1'b1, fill(16'hffff), fill(16'h8000), "R5 minus one");
  endtask

  task automatic t_bubbles();
    for (int k = 0; k < 12; k++) begin
      if (k % 2 == 0) drv(1'b1, rnd_vec(), rnd_vec(), "R6 between bubbles");
      else            drv(1'b0, fill(16'h8000), fill(16'h8000), "R6");
    end
  endtask

  initial begin
    clear_rec();
    repeat (3) @(posedge clk);
    t_reset_state();
    t_patterns();
    t_latency();
    t_stream();
    t_extremes();
    t_bubbles();
    t_midstream_reset();
    t_stream();
    idle(LAT + 2);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule